// File: doc/BRIEF.md
# Command List Sequencer

This block walks through a list of 64-bit commands held in external memory and carries each one out before fetching the next. A command can load a one-shot bit mask, write a 32-bit value to a register selected by a subsystem number and a 16-bit offset, move the program counter by a signed byte distance, wait on or clear one of a bank of sticky event flags, or end the list. Ending the list can raise a single-cycle interrupt.

A host writes the list into memory and pulses `start` with the byte address of the first command. The sequencer then requests commands one at a time over a valid/ready fetch port. Each register write is issued as a one-cycle pulse on the write bus. Hardware elsewhere sets event flags by pulsing lines of `event_pulse`. A flag stays set until a wait command consumes it. The sequencer stops in a done state after an end command, or in an error state after a command it cannot run. From either state, a new `start` launches another list.

Top module: `cmd_seq`

## Requirements
- R1: While reset is held and right after it is released, `done`, `error`, `irq`, `fetch_valid` and `wr_valid` are all low.
- R2: After `start`, the first fetch uses `start_addr`. Every command that is not a jump advances the fetch address by 8. `fetch_valid` and `fetch_addr` stay steady until `fetch_ready` is seen high, and the fetched word is the one present on `fetch_data` in that cycle.
- R3: A set-mask command (opcode 0x02) loads its low word as the write mask. The mask applies to the next write only, and afterwards the mask returns to all ones. A `start` also restores all ones.
- R4: A write command (opcode 0x04) produces exactly one `wr_valid` pulse. The pulse carries bits [55:48] as `wr_subsys`, bits [47:32] as `wr_offset`, bits [31:0] as `wr_data` and the current mask as `wr_mask`. The opcode is bits [63:56].
- R5: A jump command (opcode 0x10) sets the next fetch address to the jump's own address plus bits [31:0], read as a signed byte offset. An offset of 8 continues with the next command, and negative offsets go backwards.
- R6: A wait command (opcode 0x20) names its event in bits [47:32]. When bit 15 (wait) and bit 31 (update) of the low word are both set, the sequencer issues no fetch until that flag is set, and then clears the flag.
- R7: A wait command with update=1 and wait=0 clears the named flag and moves on without stalling.
- R8: An `event_pulse` bit sets its flag, and the flag stays set until a wait command clears it. A pulse in the same cycle as a clear of that flag leaves the flag set. A flag set before its wait command is reached lets that command pass at once.
- R9: An end command (opcode 0x40) stops fetching and holds `done` high. If bit 0 of its low word is 1, `irq` is high for exactly the first cycle of `done`.
- R10: Any other opcode, or a wait command whose event number is not below `NUM_EVENTS` (the default is 1024, so 0x400 is illegal), stops the sequencer with `error` held high and no further fetches or writes.
- R11: `start` is ignored while a list is running or waiting. From idle, done or error, `start` launches a new list and drops `done` and `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a command list |
| start_addr | input | ADDR_W | Byte address of the first command |
| fetch_valid | output | 1 | Fetch request pending |
| fetch_addr | output | ADDR_W | Byte address of the requested command |
| fetch_ready | input | 1 | Memory presents the command this cycle |
| fetch_data | input | 64 | Command word |
| wr_valid | output | 1 | Register write pulse |
| wr_subsys | output | 8 | Target subsystem number |
| wr_offset | output | 16 | Register offset inside the subsystem |
| wr_data | output | 32 | Value to write |
| wr_mask | output | 32 | Bit mask for the write |
| event_pulse | input | NUM_EVENTS | Per-event set pulses |
| done | output | 1 | List ended normally |
| error | output | 1 | List stopped on an illegal command |
| irq | output | 1 | One-cycle interrupt from an end command |

## Verification
The hardest case to reach from the ports is an event pulse that lands in exactly the cycle when a clear-only wait command executes. The bench reaches it by counting the register stages from `start`: one edge to enter fetch, one to accept the command, and one to execute it. It raises the pulse only across that third edge. The very next command waits on the same flag, so the flag's survival shows at the ports: the list finishes instead of stalling. Masks and stall conditions are swept over a fixed set of patterns, including a mismatched event number and `start` pulses sent while the sequencer is busy.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned INST_BYTES = 8;
  localparam int unsigned ARG_UPD_BIT  = 31;
  localparam int unsigned ARG_WAIT_BIT = 15;
  localparam int unsigned ARG_IRQ_BIT  = 0;

  typedef enum logic [7:0] {
    OP_MASK  = 8'h02,
    OP_WRITE = 8'h04,
    OP_JUMP  = 8'h10,
    OP_WAIT  = 8'h20,
    OP_END   = 8'h40
  } op_e;

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  subsys;
    logic [15:0] ofs;
    logic [31:0] arg;
  } inst_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_WAIT, S_DONE, S_ERR
  } state_e;

  function automatic logic is_op(logic [7:0] raw, op_e op);
    return raw == 8'(op);
  endfunction

  function automatic logic ev_in_range(logic [15:0] ev, int unsigned n);
    return {16'b0, ev} < 32'(n);
  endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 1024
) (
  input  inst_t inst,
  output logic  is_mask,
  output logic  is_write,
  output logic  is_jump,
  output logic  is_wait,
  output logic  is_end,
  output logic  ev_ok,
  output logic  upd,
  output logic  wt,
  output logic  irq_req
);
  always_comb begin
    is_mask  = is_op(inst.op, OP_MASK);
    is_write = is_op(inst.op, OP_WRITE);
    is_jump  = is_op(inst.op, OP_JUMP);
    is_wait  = is_op(inst.op, OP_WAIT);
    is_end   = is_op(inst.op, OP_END);
    ev_ok    = ev_in_range(inst.ofs, NUM_EVENTS);
    upd      = inst.arg[ARG_UPD_BIT];
    wt       = inst.arg[ARG_WAIT_BIT];
    irq_req  = inst.arg[ARG_IRQ_BIT];
  end
endmodule

// File: rtl/seq_event_flags.sv
module seq_event_flags #(
  parameter int unsigned NUM_EVENTS = 1024,
  localparam int unsigned EV_W = $clog2(NUM_EVENTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] set_pulse,
  input  logic                  clr_en,
  input  logic [EV_W-1:0]       clr_idx,
  output logic [NUM_EVENTS-1:0] flags
);
  for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_flag
    logic clr_here;
    assign clr_here = clr_en && (clr_idx == EV_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= set_pulse[g] | (flags[g] & ~clr_here);
    end
  end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_EVENTS = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     start_addr,
  output logic                  fetch_valid,
  output logic [ADDR_W-1:0]     fetch_addr,
  input  logic                  fetch_ready,
  input  logic [63:0]           fetch_data,
  output logic                  wr_valid,
  output logic [7:0]            wr_subsys,
  output logic [15:0]           wr_offset,
  output logic [31:0]           wr_data,
  output logic [31:0]           wr_mask,
  input  logic [NUM_EVENTS-1:0] event_pulse,
  output logic                  done,
  output logic                  error,
  output logic                  irq
);
  localparam int unsigned EV_W = $clog2(NUM_EVENTS);

  state_e              state_q, state_d;
  logic [ADDR_W-1:0]   pc_q, pc_d;
  inst_t               inst_q, inst_d;
  logic [31:0]         mask_q, mask_d;
  logic                irq_q, irq_d;

  logic d_mask, d_write, d_jump, d_wait, d_end, d_ev_ok, d_upd, d_wt, d_irq;
  logic [NUM_EVENTS-1:0] ev_flags;
  logic                  ev_clr_en;
  logic [EV_W-1:0]       ev_clr_idx;
  logic                  flag_hit;
  logic [ADDR_W-1:0]     pc_seq, pc_jmp;

  seq_decode #(.NUM_EVENTS(NUM_EVENTS)) u_dec (
    .inst(inst_q), .is_mask(d_mask), .is_write(d_write), .is_jump(d_jump),
    .is_wait(d_wait), .is_end(d_end), .ev_ok(d_ev_ok), .upd(d_upd),
    .wt(d_wt), .irq_req(d_irq)
  );

  seq_event_flags #(.NUM_EVENTS(NUM_EVENTS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_pulse(event_pulse),
    .clr_en(ev_clr_en), .clr_idx(ev_clr_idx), .flags(ev_flags)
  );

  assign ev_clr_idx = inst_q.ofs[EV_W-1:0];
  assign flag_hit   = ev_flags[ev_clr_idx];
  assign pc_seq     = pc_q + ADDR_W'(INST_BYTES);
  assign pc_jmp     = pc_q + ADDR_W'($signed(inst_q.arg));

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    inst_d    = inst_q;
    mask_d    = mask_q;
    irq_d     = 1'b0;
    ev_clr_en = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          state_d = S_FETCH;
          pc_d    = start_addr;
          mask_d  = '1;
        end
      end
      S_FETCH: begin
        if (fetch_ready) begin
          inst_d  = inst_t'(fetch_data);
          state_d = S_EXEC;
        end
      end
      S_EXEC: begin
        if (d_mask) begin
          mask_d  = inst_q.arg;
          pc_d    = pc_seq;
          state_d = S_FETCH;
        end else if (d_write) begin
          mask_d  = '1;
          pc_d    = pc_seq;
          state_d = S_FETCH;
        end else if (d_jump) begin
          pc_d    = pc_jmp;
          state_d = S_FETCH;
        end else if (d_wait && d_ev_ok) begin
          if (d_wt) begin
            state_d = S_WAIT;
          end else begin
            ev_clr_en = d_upd;
            pc_d      = pc_seq;
            state_d   = S_FETCH;
          end
        end else if (d_end) begin
          irq_d   = d_irq;
          state_d = S_DONE;
        end else begin
          state_d = S_ERR;
        end
      end
      S_WAIT: begin
        if (flag_hit) begin
          ev_clr_en = d_upd;
          pc_d      = pc_seq;
          state_d   = S_FETCH;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      inst_q  <= '0;
      mask_q  <= '1;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      inst_q  <= inst_d;
      mask_q  <= mask_d;
      irq_q   <= irq_d;
    end
  end

  assign fetch_valid = (state_q == S_FETCH);
  assign fetch_addr  = pc_q;
  assign wr_valid    = (state_q == S_EXEC) && d_write;
  assign wr_subsys   = inst_q.subsys;
  assign wr_offset   = inst_q.ofs;
  assign wr_data     = inst_q.arg;
  assign wr_mask     = mask_q;
  assign done        = (state_q == S_DONE);
  assign error       = (state_q == S_ERR);
  assign irq         = irq_q;
endmodule

// File: rtl/seq_checks.sv
module seq_checks #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_EVENTS = 1024,
  localparam int unsigned EV_W = $clog2(NUM_EVENTS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fetch_valid,
  input logic [ADDR_W-1:0]     fetch_addr,
  input logic                  fetch_ready,
  input logic                  wr_valid,
  input logic                  done,
  input logic                  error,
  input logic                  irq,
  input logic [NUM_EVENTS-1:0] event_pulse,
  input logic [NUM_EVENTS-1:0] ev_flags,
  input logic                  ev_clr_en,
  input logic [EV_W-1:0]       ev_clr_idx,
  input logic [31:0]           mask_q
);
  // R2: request held steady until accepted
  a_r2_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));

  // R3: mask returns to all ones after a write
  a_r3_mask_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> mask_q == '1);

  // R4: one pulse per write command
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R6: a clear without a competing set empties the flag
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr_en && !event_pulse[ev_clr_idx] |=> !ev_flags[$past(ev_clr_idx)]);

  // R8: a set in the clear cycle wins
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr_en && event_pulse[ev_clr_idx] |=> ev_flags[$past(ev_clr_idx)]);

  // R9: interrupt is one cycle and sits in the done state
  a_r9_irq_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10: a stopped sequencer stays quiet
  a_r10_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !fetch_valid && !wr_valid && !done);
endmodule

bind cmd_seq seq_checks #(.ADDR_W(ADDR_W), .NUM_EVENTS(NUM_EVENTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .fetch_ready(fetch_ready), .wr_valid(wr_valid), .done(done), .error(error),
  .irq(irq), .event_pulse(event_pulse), .ev_flags(ev_flags),
  .ev_clr_en(ev_clr_en), .ev_clr_idx(ev_clr_idx), .mask_q(mask_q)
);

// File: tb/cmd_seq_tb.sv
`timescale 1ns/1ps
module cmd_seq_tb;
  localparam int AW = 32;
  localparam int NE = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic          fetch_ready = 1'b1;
  logic [63:0]   fetch_data;
  logic          wr_valid;
  logic [7:0]    wr_subsys;
  logic [15:0]   wr_offset;
  logic [31:0]   wr_data, wr_mask;
  logic [NE-1:0] event_pulse = '0;
  logic          done, error, irq;

  logic [63:0] mem [64];
  logic        ready_mode = 1'b0;
  int          n_chk = 0, n_fail = 0;
  int          w_cnt = 0, irq_cnt = 0;
  logic [87:0] w_log [16];

  always #2 clk = ~clk;

  cmd_seq #(.ADDR_W(AW), .NUM_EVENTS(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .fetch_data(fetch_data), .wr_valid(wr_valid), .wr_subsys(wr_subsys),
    .wr_offset(wr_offset), .wr_data(wr_data), .wr_mask(wr_mask),
    .event_pulse(event_pulse), .done(done), .error(error), .irq(irq)
  );

  assign fetch_data = mem[fetch_addr[8:3]];

  always @(negedge clk) begin
    fetch_ready <= ready_mode ? ~fetch_ready : 1'b1;
    if (wr_valid && w_cnt < 16) begin
      w_log[w_cnt] = {wr_subsys, wr_offset, wr_data, wr_mask};
      w_cnt = w_cnt + 1;
    end
    if (irq) irq_cnt = irq_cnt + 1;
  end

  function automatic logic [63:0] ins(logic [7:0] op, logic [7:0] sb,
                                      logic [15:0] of, logic [31:0] ag);
    return {op, sb, of, ag};
  endfunction

  task automatic chk(input string req, input logic [87:0] act, input logic [87:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] a);
    w_cnt = 0;
    irq_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input int max);
    for (int i = 0; i < max && !(done || error); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ev(input int e);
    @(negedge clk);
    event_pulse[e] = 1'b1;
    @(negedge clk);
    event_pulse[e] = 1'b0;
  endtask

  task automatic check_prog_a(input string tag);
    chk({tag, " R9 done"}, 88'(done), 88'd1);
    chk({tag, " R9 irq once"}, 88'(irq_cnt), 88'd1);
    chk({tag, " R5 write count"}, 88'(w_cnt), 88'd3);
    chk({tag, " R3 masked write"}, w_log[0], {8'd3, 16'h0040, 32'hDEADBEEF, 32'h00FF00FF});
    chk({tag, " R3 mask reset"}, w_log[1], {8'd5, 16'h0010, 32'h12345678, 32'hFFFFFFFF});
    chk({tag, " R4 write after jumps"}, w_log[2], {8'd7, 16'h0100, 32'hCAFEF00D, 32'hFFFFFFFF});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // program A at 0x000
    mem[0]  = ins(8'h02, 8'd0, 16'h0, 32'h00FF00FF);
    mem[1]  = ins(8'h04, 8'd3, 16'h0040, 32'hDEADBEEF);
    mem[2]  = ins(8'h04, 8'd5, 16'h0010, 32'h12345678);
    mem[3]  = ins(8'h10, 8'd0, 16'h0, 32'd16);
    mem[4]  = ins(8'h04, 8'hEE, 16'h0, 32'h0BADBAD0);
    mem[5]  = ins(8'h10, 8'd0, 16'h0, 32'd8);
    mem[6]  = ins(8'h04, 8'd7, 16'h0100, 32'hCAFEF00D);
    mem[7]  = ins(8'h40, 8'd0, 16'h0, 32'd1);
    // program B at 0x040: backward jump
    mem[8]  = ins(8'h10, 8'd0, 16'h0, 32'd16);
    mem[9]  = ins(8'h40, 8'd0, 16'h0, 32'd0);
    mem[10] = ins(8'h04, 8'd1, 16'h0002, 32'h0000A5A5);
    mem[11] = ins(8'h10, 8'd0, 16'h0, 32'hFFFFFFF0);
    // program W at 0x060: wait on event 700
    mem[12] = ins(8'h20, 8'd0, 16'd700, 32'h80008000);
    mem[13] = ins(8'h04, 8'd2, 16'h0004, 32'h00000011);
    mem[14] = ins(8'h40, 8'd0, 16'h0, 32'd1);
    // program C at 0x080: clear only, then wait on event 3
    mem[16] = ins(8'h20, 8'd0, 16'd3, 32'h80000000);
    mem[17] = ins(8'h20, 8'd0, 16'd3, 32'h80008000);
    mem[18] = ins(8'h40, 8'd0, 16'h0, 32'd0);
    // program X at 0x0A0: undefined opcode
    mem[20] = ins(8'h04, 8'd9, 16'h0000, 32'h00000077);
    mem[21] = ins(8'h08, 8'd0, 16'h0, 32'd0);
    mem[22] = ins(8'h40, 8'd0, 16'h0, 32'd1);
    // program R at 0x0C0: event out of range
    mem[24] = ins(8'h20, 8'd0, 16'h0400, 32'h80008000);
    mem[25] = ins(8'h40, 8'd0, 16'h0, 32'd1);
    // program P at 0x100: preset event 10
    mem[32] = ins(8'h20, 8'd0, 16'd10, 32'h80008000);
    mem[33] = ins(8'h40, 8'd0, 16'h0, 32'd1);

    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 88'({done, error, irq, fetch_valid, wr_valid}), 88'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 88'({done, error, irq, fetch_valid, wr_valid}), 88'd0);

    run(32'h000);
    wait_end(200);
    check_prog_a("ready high");

    ready_mode = 1'b1;
    run(32'h000);
    wait_end(400);
    check_prog_a("R2 ready toggling");
    ready_mode = 1'b0;

    run(32'h040);
    wait_end(200);
    chk("R5 backward jump write count", 88'(w_cnt), 88'd1);
    chk("R5 backward jump write", w_log[0], {8'd1, 16'h0002, 32'h0000A5A5, 32'hFFFFFFFF});
    chk("R9 no irq without flag", 88'({done, 7'(irq_cnt)}), {80'd0, 1'b1, 7'd0});

    run(32'h060);
    repeat (30) @(negedge clk);
    chk("R6 stall", 88'({done, fetch_valid, 6'(w_cnt)}), 88'd0);
    pulse_ev(5);
    run(32'h000);
    repeat (10) @(negedge clk);
    chk("R11 start ignored while waiting", 88'({done, 7'(w_cnt)}), 88'd0);
    pulse_ev(700);
    wait_end(50);
    chk("R6 resume write", w_log[0], {8'd2, 16'h0004, 32'h00000011, 32'hFFFFFFFF});
    chk("R6 resume done irq", 88'({done, 7'(irq_cnt), 8'(w_cnt)}), {72'd0, 1'b1, 7'd1, 8'd1});
    run(32'h060);
    repeat (30) @(negedge clk);
    chk("R6 flag consumed", 88'(done), 88'd0);
    pulse_ev(700);
    wait_end(50);
    chk("R6 second pass done", 88'(done), 88'd1);

    pulse_ev(3);
    run(32'h080);
    repeat (30) @(negedge clk);
    chk("R7 clear only removed flag", 88'({done, fetch_valid}), 88'd0);
    pulse_ev(3);
    wait_end(50);
    chk("R7 finish after new event", 88'({done, error}), 88'b10);

    // set coincides with the clear-only command's execute edge
    run(32'h080);
    @(negedge clk);
    event_pulse[3] = 1'b1;
    @(negedge clk);
    event_pulse[3] = 1'b0;
    wait_end(20);
    chk("R8 set wins over clear", 88'(done), 88'd1);

    run(32'h0A0);
    wait_end(50);
    repeat (5) @(negedge clk);
    chk("R10 undefined opcode", 88'({error, done, fetch_valid}), 88'b100);
    chk("R10 no write after stop", 88'(w_cnt), 88'd1);

    run(32'h0C0);
    wait_end(50);
    chk("R10 event out of range", 88'({error, done}), 88'b10);

    pulse_ev(10);
    run(32'h100);
    wait_end(20);
    chk("R11 restart from error", 88'({error, done, 6'(irq_cnt)}), {80'd0, 2'b01, 6'd1});
    chk("R8 preset flag no stall", 88'(done), 88'd1);

    for (int k = 0; k < 8; k++) begin
      logic [31:0] m, v;
      case (k)
        0: m = 32'h00000000;
        1: m = 32'hFFFFFFFF;
        2: m = 32'h000000FF;
        3: m = 32'hFF000000;
        4: m = 32'hA5A55A5A;
        5: m = 32'h0F0F0F0F;
        6: m = 32'h80000001;
        default: m = 32'h12345678;
      endcase
      v = m ^ 32'h5555AAAA;
      mem[28] = ins(8'h02, 8'd0, 16'h0, m);
      mem[29] = ins(8'h04, 8'd4, 16'h0008, v);
      mem[30] = ins(8'h04, 8'd4, 16'h000C, ~v);
      mem[31] = ins(8'h40, 8'd0, 16'h0, 32'd0);
      run(32'h0E0);
      wait_end(50);
      chk("R3 sweep first write", w_log[0], {8'd4, 16'h0008, v, m});
      chk("R3 sweep second write", w_log[1], {8'd4, 16'h000C, ~v, 32'hFFFFFFFF});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule